// File: doc/BRIEF.md
# Serial Flash Configuration Register Guard

This block holds the one-byte configuration register of a serial flash device, together with the three block-protect (BP) bits of its status register. It takes write requests and applies a separate persistence and lock rule to each bit. Three configuration bits are one-time programmable (OTP). One of them decides whether the BP bits survive resets or reload a full-protect pattern. A freeze bit locks the protection settings until a hardware reset or a power-on reset. A program-error flag is raised whenever a write tries to return an OTP bit to zero.

The surrounding command logic presents a write strobe together with a new configuration byte and new BP value. It also drives the three reset sources: an asynchronous active-low power-on reset, a synchronous hardware reset and a synchronous command (software) reset. Bits that are non-volatile in the device are modelled as flops that no reset input touches. They start from a parameterised shipping value.

Top module: `flash_cfg_guard`

## Requirements
- R1: The configuration byte reads as follows: bit 5 means protection counts from address zero, bit 3 means the BP bits are volatile, bit 2 means the parameter block is at the top, bit 1 enables quad width and bit 0 is freeze. Bits 7, 6 and 4 always read 0 and ignore writes.
- R2: Bits 5, 3 and 2 can only be set. A write of 0 to one of these bits while it holds 1 leaves it at 1 and sets the program-error flag.
- R3: While bit 3 is 1, the BP bits read 3'b111 after a power-on reset, a hardware reset or a command reset.
- R4: While bit 3 is 0, the BP bits keep their value through every kind of reset.
- R5: Freeze is set by a write, and the other bits of that same write take effect in the same cycle. Writing 0 to freeze has no effect. A command reset leaves freeze set. A hardware reset or a power-on reset clears it.
- R6: While freeze is 1, the lock output is 1 and writes to the BP bits, bit 5 and bit 2 are ignored without raising an error. Bits 3 and 1 stay writable. Setting bit 3 while frozen leaves the BP value seen at the output unchanged.
- R7: The quad bit follows every accepted write, in either direction, and survives every reset.
- R8: The program-error flag stays set until a power-on reset or the clear input. Hardware and command resets do not clear it. A new error in the same cycle as a clear leaves the flag set.
- R9: A write presented in the same cycle as a hardware or command reset is discarded entirely.
- R10: An accepted write is visible on the outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| hwRst | input | 1 | Hardware reset, synchronous, active high |
| cmdRst | input | 1 | Command (software) reset, synchronous, active high |
| wrEn | input | 1 | Write strobe for configuration and BP values |
| wrCfg | input | 8 | New configuration byte |
| wrBp | input | 3 | New block-protect value |
| errClr | input | 1 | Clears the program-error flag |
| cfgOut | output | 8 | Current configuration byte |
| bpOut | output | 3 | Current block-protect value |
| protLock | output | 1 | Protection settings are frozen |
| progErr | output | 1 | Program-error flag |

## Verification
A single sequence of writes and resets walks the block through its life. It starts with plain quad and BP writes, then sets the OTP bits, tries to clear them, freezes the register and finally switches the BP bits to volatile. Each reset kind is applied with BP non-volatile and again with BP volatile. This tells preserving behaviour apart from the 3'b111 reload, and command reset apart from hardware reset on freeze. Writes that try to clear an OTP bit are sent with freeze on and with freeze off, which separates the ignored case from the error case. Further tests cover a write that arrives together with a reset, an error arriving in the same cycle as a clear, and a power-on reset taken while freeze and the error flag are both set.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  localparam int CFG_W = 8;
  localparam int BP_W  = 3;

  // bit positions decoded by neighbouring logic
  localparam int BIT_FRZ   = 0;
  localparam int BIT_QUAD  = 1;
  localparam int BIT_PARM  = 2;
  localparam int BIT_BPVOL = 3;
  localparam int BIT_PROT  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBpVolSel;  // OR new bit 3 into its OTP flop
    logic wrProtParm;  // OR new bits 5 and 2 into their OTP flops
    logic wrQuad;      // load quad bit
    logic setFreeze;
    logic clrFreeze;
    logic wrNvBp;      // load non-volatile BP copy
    logic wrVolBp;     // load volatile BP copy from write data
    logic seedVolBp;   // copy non-volatile BP into volatile copy
    logic presetVolBp; // volatile BP to all ones
    logic errSet;
    logic errClr;
  } cfgStrobe_t;

endpackage

// File: rtl/flash_cfg_ctrl.sv
module flash_cfg_ctrl
  import flash_cfg_pkg::*;
#(
  parameter int CFG_W_P = CFG_W
) (
  input  logic               wrEn,
  input  logic [CFG_W_P-1:0] wrCfg,
  input  logic               hwRst,
  input  logic               cmdRst,
  input  logic               errClrIn,
  input  logic               curProt,
  input  logic               curBpVol,
  input  logic               curParm,
  input  logic               curFreeze,
  output cfgStrobe_t         strobe
);

  logic anyRst;
  logic wrOk;
  logic clrProt;
  logic clrParm;
  logic clrBpVol;

  assign anyRst = hwRst | cmdRst;
  assign wrOk   = wrEn & ~anyRst;

  // attempted clears of OTP bits; bits 5 and 2 count only when not frozen
  assign clrProt  = curProt  & ~wrCfg[BIT_PROT] & ~curFreeze;
  assign clrParm  = curParm  & ~wrCfg[BIT_PARM] & ~curFreeze;
  assign clrBpVol = curBpVol & ~wrCfg[BIT_BPVOL];

  always_comb begin
    strobe             = '0;
    strobe.wrBpVolSel  = wrOk;
    strobe.wrProtParm  = wrOk & ~curFreeze;
    strobe.wrQuad      = wrOk;
    strobe.setFreeze   = wrOk & wrCfg[BIT_FRZ];
    strobe.clrFreeze   = hwRst;
    strobe.wrNvBp      = wrOk & ~curFreeze & ~curBpVol;
    strobe.wrVolBp     = wrOk & ~curFreeze;
    strobe.seedVolBp   = wrOk & curFreeze & ~curBpVol & wrCfg[BIT_BPVOL];
    strobe.presetVolBp = anyRst;
    strobe.errSet      = wrOk & (clrProt | clrParm | clrBpVol);
    strobe.errClr      = errClrIn;
  end

endmodule

// File: rtl/flash_cfg_dp.sv
module flash_cfg_dp
  import flash_cfg_pkg::*;
#(
  parameter int          CFG_W_P   = CFG_W,
  parameter int          BP_W_P    = BP_W,
  parameter logic        SHIP_PROT = 1'b0,
  parameter logic        SHIP_VOL  = 1'b0,
  parameter logic        SHIP_PARM = 1'b0,
  parameter logic        SHIP_QUAD = 1'b0,
  parameter logic [BP_W_P-1:0] SHIP_BP = '0
) (
  input  logic               clk,
  input  logic               porN,
  input  cfgStrobe_t         strobe,
  input  logic [CFG_W_P-1:0] wrCfg,
  input  logic [BP_W_P-1:0]  wrBp,
  output logic               curProt,
  output logic               curBpVol,
  output logic               curParm,
  output logic               curFreeze,
  output logic [CFG_W_P-1:0] cfgOut,
  output logic [BP_W_P-1:0]  bpOut,
  output logic               progErr
);

  localparam logic [CFG_W_P-1:0] IMPL_MASK =
    CFG_W_P'((1 << BIT_PROT) | (1 << BIT_BPVOL) | (1 << BIT_PARM) |
             (1 << BIT_QUAD) | (1 << BIT_FRZ));

  // non-volatile storage: no reset reaches these flops
  logic              nvProt = SHIP_PROT;
  logic              nvBpVol = SHIP_VOL;
  logic              nvParm = SHIP_PARM;
  logic              nvQuad = SHIP_QUAD;
  logic [BP_W_P-1:0] nvBp = SHIP_BP;

  // volatile storage
  logic [BP_W_P-1:0] volBp;
  logic              freezeQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (strobe.wrProtParm) begin
      nvProt <= nvProt | wrCfg[BIT_PROT];
      nvParm <= nvParm | wrCfg[BIT_PARM];
    end
    if (strobe.wrBpVolSel) nvBpVol <= nvBpVol | wrCfg[BIT_BPVOL];
    if (strobe.wrQuad)     nvQuad  <= wrCfg[BIT_QUAD];
    if (strobe.wrNvBp)     nvBp    <= wrBp;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      volBp   <= '1;
      freezeQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (strobe.presetVolBp)    volBp <= '1;
      else if (strobe.wrVolBp)   volBp <= wrBp;
      else if (strobe.seedVolBp) volBp <= nvBp;

      if (strobe.clrFreeze)      freezeQ <= 1'b0;
      else if (strobe.setFreeze) freezeQ <= 1'b1;

      if (strobe.errSet)         errQ <= 1'b1;
      else if (strobe.errClr)    errQ <= 1'b0;
    end
  end

  logic [CFG_W_P-1:0] cfgRaw;

  always_comb begin
    cfgRaw            = '0;
    cfgRaw[BIT_PROT]  = nvProt;
    cfgRaw[BIT_BPVOL] = nvBpVol;
    cfgRaw[BIT_PARM]  = nvParm;
    cfgRaw[BIT_QUAD]  = nvQuad;
    cfgRaw[BIT_FRZ]   = freezeQ;
  end

  for (genvar i = 0; i < CFG_W_P; i++) begin : g_cfgBit
    if (IMPL_MASK[i]) begin : g_used
      assign cfgOut[i] = cfgRaw[i];
    end else begin : g_rsvd
      assign cfgOut[i] = 1'b0;
    end
  end

  assign bpOut     = nvBpVol ? volBp : nvBp;
  assign progErr   = errQ;
  assign curProt   = nvProt;
  assign curBpVol  = nvBpVol;
  assign curParm   = nvParm;
  assign curFreeze = freezeQ;

endmodule

// File: rtl/flash_cfg_guard.sv
module flash_cfg_guard
  import flash_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             hwRst,
  input  logic             cmdRst,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrCfg,
  input  logic [BP_W-1:0]  wrBp,
  input  logic             errClr,
  output logic [CFG_W-1:0] cfgOut,
  output logic [BP_W-1:0]  bpOut,
  output logic             protLock,
  output logic             progErr
);

  cfgStrobe_t strobe;
  logic curProt;
  logic curBpVol;
  logic curParm;
  logic curFreeze;

  flash_cfg_ctrl #(.CFG_W_P(CFG_W)) u_ctrl (
    .wrEn      (wrEn),
    .wrCfg     (wrCfg),
    .hwRst     (hwRst),
    .cmdRst    (cmdRst),
    .errClrIn  (errClr),
    .curProt   (curProt),
    .curBpVol  (curBpVol),
    .curParm   (curParm),
    .curFreeze (curFreeze),
    .strobe    (strobe)
  );

  flash_cfg_dp #(.CFG_W_P(CFG_W), .BP_W_P(BP_W)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .wrCfg     (wrCfg),
    .wrBp      (wrBp),
    .curProt   (curProt),
    .curBpVol  (curBpVol),
    .curParm   (curParm),
    .curFreeze (curFreeze),
    .cfgOut    (cfgOut),
    .bpOut     (bpOut),
    .progErr   (progErr)
  );

  assign protLock = curFreeze;

endmodule

// File: rtl/flash_cfg_guard_chk.sv
module flash_cfg_guard_chk (
  input logic       clk,
  input logic       porN,
  input logic       hwRst,
  input logic       cmdRst,
  input logic       wrEn,
  input logic [7:0] wrCfg,
  input logic       errClr,
  input logic [7:0] cfgOut,
  input logic [2:0] bpOut,
  input logic       protLock,
  input logic       progErr
);

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!porN)
    cfgOut[5] |=> cfgOut[5]); // R2

  AST_BPVOL_STICKY: assert property (@(posedge clk) disable iff (!porN)
    cfgOut[3] |=> cfgOut[3]); // R2

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && !hwRst && !cmdRst && cfgOut[3] && !wrCfg[3]) |=> progErr); // R2

  AST_VOL_PRESET: assert property (@(posedge clk) disable iff (!porN)
    ((hwRst || cmdRst) && cfgOut[3]) |=> (bpOut == 3'b111)); // R3

  AST_NV_KEEP: assert property (@(posedge clk) disable iff (!porN)
    ((hwRst || cmdRst) && !cfgOut[3]) |=> $stable(bpOut)); // R4

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (protLock && !hwRst) |=> protLock); // R5

  AST_FROZEN_BP: assert property (@(posedge clk) disable iff (!porN)
    (protLock && !hwRst && !cmdRst) |=> $stable(bpOut)); // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (progErr && !errClr) |=> progErr); // R8

  AST_CMD_DROP: assert property (@(posedge clk) disable iff (!porN)
    cmdRst |=> $stable(cfgOut)); // R9

endmodule

bind flash_cfg_guard flash_cfg_guard_chk u_chk (.*);

// File: tb/flash_cfg_guard_tb.sv
module flash_cfg_guard_tb;

  logic       clk = 1'b0;
  logic       porN;
  logic       hwRst;
  logic       cmdRst;
  logic       wrEn;
  logic [7:0] wrCfg;
  logic [2:0] wrBp;
  logic       errClr;
  logic [7:0] cfgOut;
  logic [2:0] bpOut;
  logic       protLock;
  logic       progErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cfg_guard u_dut (
    .clk(clk), .porN(porN), .hwRst(hwRst), .cmdRst(cmdRst), .wrEn(wrEn),
    .wrCfg(wrCfg), .wrBp(wrBp), .errClr(errClr), .cfgOut(cfgOut),
    .bpOut(bpOut), .protLock(protLock), .progErr(progErr)
  );

  // rst: 0 none, 1 command reset, 2 hardware reset
  typedef struct packed {
    logic [1:0] rst;
    logic       wr;
    logic       clr;
    logic [7:0] cfg;
    logic [2:0] bp;
    logic [7:0] eCfg;
    logic [2:0] eBp;
    logic       eErr;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 1'b0, 8'h02, 3'b010, 8'h02, 3'b010, 1'b0, 4'd7},  // R7 R10 quad on
    '{2'd0, 1'b1, 1'b0, 8'hD2, 3'b010, 8'h02, 3'b010, 1'b0, 4'd1},  // R1 reserved bits
    '{2'd1, 1'b0, 1'b0, 8'h00, 3'b000, 8'h02, 3'b010, 1'b0, 4'd4},  // R4 cmd reset
    '{2'd2, 1'b0, 1'b0, 8'h00, 3'b000, 8'h02, 3'b010, 1'b0, 4'd4},  // R4 hw reset
    '{2'd0, 1'b1, 1'b0, 8'h24, 3'b100, 8'h24, 3'b100, 1'b0, 4'd2},  // R2 set OTP
    '{2'd0, 1'b1, 1'b0, 8'h00, 3'b100, 8'h24, 3'b100, 1'b1, 4'd2},  // R2 clear attempt
    '{2'd0, 1'b0, 1'b1, 8'h00, 3'b000, 8'h24, 3'b100, 1'b0, 4'd8},  // R8 clear input
    '{2'd0, 1'b1, 1'b0, 8'h26, 3'b001, 8'h26, 3'b001, 1'b0, 4'd7},  // R7
    '{2'd2, 1'b1, 1'b0, 8'h00, 3'b111, 8'h26, 3'b001, 1'b0, 4'd9},  // R9 write dropped
    '{2'd0, 1'b1, 1'b0, 8'h27, 3'b011, 8'h27, 3'b011, 1'b0, 4'd5},  // R5 freeze with data
    '{2'd0, 1'b1, 1'b0, 8'h06, 3'b111, 8'h27, 3'b011, 1'b0, 4'd6},  // R6 frozen write
    '{2'd1, 1'b0, 1'b0, 8'h00, 3'b000, 8'h27, 3'b011, 1'b0, 4'd5},  // R5 cmd keeps freeze
    '{2'd0, 1'b1, 1'b0, 8'h2F, 3'b000, 8'h2F, 3'b011, 1'b0, 4'd6},  // R6 bit 3 while frozen
    '{2'd1, 1'b0, 1'b0, 8'h00, 3'b000, 8'h2F, 3'b111, 1'b0, 4'd3},  // R3 cmd reset
    '{2'd2, 1'b0, 1'b0, 8'h00, 3'b000, 8'h2E, 3'b111, 1'b0, 4'd5},  // R5 R3 hw reset
    '{2'd0, 1'b1, 1'b0, 8'h2C, 3'b101, 8'h2C, 3'b101, 1'b0, 4'd7},  // R7 quad off
    '{2'd0, 1'b1, 1'b0, 8'h24, 3'b101, 8'h2C, 3'b101, 1'b1, 4'd2},  // R2 clear bit 3
    '{2'd1, 1'b0, 1'b0, 8'h00, 3'b000, 8'h2C, 3'b111, 1'b1, 4'd8},  // R8 cmd keeps err
    '{2'd0, 1'b0, 1'b1, 8'h00, 3'b000, 8'h2C, 3'b111, 1'b0, 4'd8}   // R8
  };

  task automatic chk(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input int req, input logic [7:0] eCfg, input logic [2:0] eBp,
                        input logic eErr);
    chk("cfgOut", req, int'(cfgOut), int'(eCfg));
    chk("bpOut", req, int'(bpOut), int'(eBp));
    chk("progErr", req, int'(progErr), int'(eErr));
    chk("protLock", req, int'(protLock), int'(eCfg[0]));
  endtask

  task automatic idle();
    hwRst = 1'b0; cmdRst = 1'b0; wrEn = 1'b0; errClr = 1'b0;
    wrCfg = 8'h00; wrBp = 3'b000;
  endtask

  task automatic porPulse();
    @(negedge clk); porN = 1'b0;
    @(negedge clk); @(negedge clk); porN = 1'b1;
  endtask

  initial begin
    porN = 1'b0;
    idle();
    @(negedge clk); @(negedge clk); porN = 1'b1;
    // R1 reset state: shipped zeros, no lock, no error
    chkAll(1, 8'h00, 3'b000, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      hwRst  = (VEC[i].rst == 2'd2);
      cmdRst = (VEC[i].rst == 2'd1);
      wrEn   = VEC[i].wr;
      errClr = VEC[i].clr;
      wrCfg  = VEC[i].cfg;
      wrBp   = VEC[i].bp;
      @(negedge clk);
      idle();
      chkAll(int'(VEC[i].req), VEC[i].eCfg, VEC[i].eBp, VEC[i].eErr);
    end

    // R8: error and clear in the same cycle -> flag set; volatile BP loads 000
    wrEn = 1'b1; wrCfg = 8'h24; wrBp = 3'b000; errClr = 1'b1;
    @(negedge clk); idle();
    chkAll(8, 8'h2C, 3'b000, 1'b1);

    // R5: freeze again, then power-on reset clears freeze and error
    wrEn = 1'b1; wrCfg = 8'h2D; wrBp = 3'b010;
    @(negedge clk); idle();
    chkAll(5, 8'h2D, 3'b010, 1'b1);
    porPulse();
    // R3 volatile BP reloads ones; R7 quad/OTP kept; R8 error cleared
    chkAll(3, 8'h2C, 3'b111, 1'b0);

    // R10: write lands on the very next edge
    wrEn = 1'b1; wrCfg = 8'h2E; wrBp = 3'b110;
    @(negedge clk); idle();
    chkAll(10, 8'h2E, 3'b110, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule